// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Sequencer

This block carries out vectored interrupt entry in the classic 16-bit style, for use when protection is switched off. A one-cycle `start` hands it a vector number, the table base, and the interrupted context: flags, code selector, instruction pointer, stack pointer and stack segment. The block then makes five word-wide memory accesses, one after another, on a simple request/acknowledge port. First it reads the handler offset and the handler selector from the vector table. Then it pushes the old flags, the old code selector and the old instruction pointer onto the stack.

After the last push it produces the handler context: the new code selector, a code base equal to that selector times 16, a zero-extended instruction pointer, the masked flags and the updated stack pointer. It also raises `done` for one cycle. In that same cycle `lim_fault` reports whether the new instruction pointer lies beyond the code segment limit. The surrounding core must not start the handler when it does. The sequence is always 16-bit: the code-size bit and the operand/address-size prefixes do not change any part of it.

Top module: `rmi_vector_entry`

## Requirements
- R1: The handler offset is read from linear address `tbl_base + 4*vec` and the handler selector from that address plus 2, with arithmetic modulo 2^32 and no segment base added.
- R2: Exactly five accesses are made in this order: a read of the offset, a read of the selector, then three writes. The writes carry `flags_in[15:0]`, then `cs_sel_in`, then `eip_in[15:0]`.
- R3: In the `done` cycle, `eip_out` equals the fetched offset zero-extended to 32 bits, whatever the upper half of `eip_in` held.
- R4: In the `done` cycle, `cs_sel_out` equals the fetched selector and `cs_base_out` equals that selector shifted left by 4.
- R5: `flags_out` equals `flags_in` with bits 8, 9, 16 and 18 cleared and every other bit unchanged.
- R6: Each push first subtracts 2 from the stack pointer and then writes at `ss_base` plus that pointer. With `ss_big` = 0, only bits 15:0 change, with wrap-around within 64K, and only those bits form the address. With `ss_big` = 1, the full 32-bit pointer is used. `esp_out` holds the pointer after the third push.
- R7: `code_big`, `opsz_pfx` and `adsz_pfx` have no effect on any access, written value or result.
- R8: In the `done` cycle, `lim_fault` is 1 exactly when the new instruction pointer is greater than `cs_limit`.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values, and the step completes on the first acknowledged cycle.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` lasts exactly one cycle. `start` is ignored while `busy` is high.
- R11: Under reset, `busy`, `done`, `mem_req`, `mem_we` and `lim_fault` are 0 and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an entry sequence (sampled when idle) |
| vec | input | 8 | Vector number |
| tbl_base | input | 32 | Linear base of the vector table |
| flags_in | input | 32 | Flags of the interrupted code |
| cs_sel_in | input | 16 | Code selector of the interrupted code |
| eip_in | input | 32 | Instruction pointer of the interrupted code |
| esp_in | input | 32 | Stack pointer of the interrupted code |
| ss_base | input | 32 | Stack segment base |
| ss_big | input | 1 | Stack size bit: 0 = 16-bit pointer, 1 = 32-bit pointer |
| cs_limit | input | 32 | Code segment limit |
| code_big | input | 1 | Code default-size bit (ignored) |
| opsz_pfx | input | 1 | Operand-size prefix seen (ignored) |
| adsz_pfx | input | 1 | Address-size prefix seen (ignored) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| lim_fault | output | 1 | New instruction pointer beyond `cs_limit` |
| cs_sel_out | output | 16 | Handler code selector |
| cs_base_out | output | 32 | Handler code base |
| eip_out | output | 32 | Handler instruction pointer |
| flags_out | output | 32 | Flags for the handler |
| esp_out | output | 32 | Stack pointer after the pushes |

## Verification
Two functions meet in one cycle in this block: the completion pulse, and a `start` request that must be refused. The bench holds `start` high across a whole sequence, so a request sits on the port during every busy cycle, including the `done` cycle. It then expects the second sequence to begin only after the return to idle, which gives exactly two completions in fourteen cycles. The limit verdict and the handler context also settle in the same cycle. A behavioural model, stepped with the same acknowledge pattern, judges every port on every clock, both with acknowledges every cycle and with stalls.

// File: rtl/rmi_pkg.sv
// Package: shared state encoding and flag bit positions for the
// real-mode interrupt entry sequencer.
// Assumes a flags word of at least 19 bits.
package rmi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_IP  = 3'd1,
        ST_RD_CS  = 3'd2,
        ST_PSH_FL = 3'd3,
        ST_PSH_CS = 3'd4,
        ST_PSH_IP = 3'd5,
        ST_FIN    = 3'd6
    } rmi_state_e;

    // Flag bit positions cleared on entry
    localparam int FL_TF = 8;
    localparam int FL_IF = 9;
    localparam int FL_RF = 16;
    localparam int FL_AC = 18;

endpackage

// File: rtl/rmi_vec_addr.sv
// Module: rmi_vec_addr
// Forms the linear address of one half of a vector table entry.
// Assumes each entry is 2**ENT_SHIFT bytes, offset word first, selector word second.
// No segment base is applied; the sum wraps modulo 2**AW.
module rmi_vec_addr #(
    parameter int AW        = 32,
    parameter int VW        = 8,
    parameter int ENT_SHIFT = 2
) (
    input  logic [AW-1:0] tbl_base,
    input  logic [VW-1:0] vec,
    input  logic          hi_half,
    output logic [AW-1:0] addr
);
    localparam int HALF_OFF = (1 << ENT_SHIFT) / 2;

    logic [AW-1:0] ent_off;

    // Scale the vector number into a byte offset
    always_comb ent_off = AW'(vec) << ENT_SHIFT;

    // Add base, entry offset and half select
    always_comb addr = tbl_base + ent_off + (hi_half ? AW'(HALF_OFF) : '0);

endmodule

// File: rtl/rmi_stack_ptr.sv
// Module: rmi_stack_ptr
// Computes the pre-decremented stack pointer and the push address.
// Assumes STEP-byte pushes. With big = 0 only the low WW bits move and address,
// the upper bits are carried through untouched.
module rmi_stack_ptr #(
    parameter int AW   = 32,
    parameter int WW   = 16,
    parameter int STEP = 2
) (
    input  logic [AW-1:0] esp_cur,
    input  logic [AW-1:0] ss_base,
    input  logic          big,
    output logic [AW-1:0] esp_dec,
    output logic [AW-1:0] push_addr
);
    localparam int HI_W = AW - WW;

    logic [WW-1:0] sp_small;
    logic [AW-1:0] eff_ptr;

    // Narrow decrement with wrap inside the low window
    always_comb sp_small = esp_cur[WW-1:0] - WW'(STEP);

    // Select the full or narrow update
    always_comb esp_dec = big ? (esp_cur - AW'(STEP)) : {esp_cur[AW-1:WW], sp_small};

    // Pointer part that takes part in addressing
    always_comb eff_ptr = big ? esp_dec : {{HI_W{1'b0}}, esp_dec[WW-1:0]};

    // Stack address = segment base + effective pointer
    always_comb push_addr = ss_base + eff_ptr;

endmodule

// File: rtl/rmi_entry_result.sv
// Module: rmi_entry_result
// Builds the handler context from the fetched words: zero-extended IP,
// code base from the selector, masked flags, and the limit verdict.
// Assumes AW > FL_AC and AW >= WW + SEG_SHIFT.
module rmi_entry_result #(
    parameter int AW        = 32,
    parameter int WW        = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [AW-1:0] flags_old,
    input  logic [WW-1:0] ip_new,
    input  logic [WW-1:0] sel_new,
    input  logic [AW-1:0] cs_limit,
    output logic [AW-1:0] flags_new,
    output logic [AW-1:0] eip_new,
    output logic [AW-1:0] base_new,
    output logic          over_limit
);
    import rmi_pkg::*;

    localparam logic [AW-1:0] CLR_MASK = (AW'(1) << FL_TF) | (AW'(1) << FL_IF) |
                                         (AW'(1) << FL_RF) | (AW'(1) << FL_AC);

    // Clear the entry-masked flag bits
    always_comb flags_new = flags_old & ~CLR_MASK;

    // Zero-extend the fetched offset
    always_comb eip_new = AW'(ip_new);

    // Selector times 16 gives the code base
    always_comb base_new = AW'(sel_new) << SEG_SHIFT;

    // Limit check of the handler entry point
    always_comb over_limit = eip_new > cs_limit;

endmodule

// File: rtl/rmi_vector_entry.sv
// Module: rmi_vector_entry (top)
// Sequences a 16-bit style vectored interrupt entry: two table reads, three
// stack pushes, then a one-cycle done with the handler context.
// Assumes a single outstanding memory access and that the requester keeps
// start low or ignored while busy. Size bits and prefixes are not used.
module rmi_vector_entry #(
    parameter int AW        = 32,
    parameter int WW        = 16,
    parameter int VW        = 8,
    parameter int ENT_SHIFT = 2,
    parameter int SEG_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] vec,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] flags_in,
    input  logic [WW-1:0] cs_sel_in,
    input  logic [AW-1:0] eip_in,
    input  logic [AW-1:0] esp_in,
    input  logic [AW-1:0] ss_base,
    input  logic          ss_big,
    input  logic [AW-1:0] cs_limit,
    input  logic          code_big,
    input  logic          opsz_pfx,
    input  logic          adsz_pfx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic          lim_fault,
    output logic [WW-1:0] cs_sel_out,
    output logic [AW-1:0] cs_base_out,
    output logic [AW-1:0] eip_out,
    output logic [AW-1:0] flags_out,
    output logic [AW-1:0] esp_out
);
    import rmi_pkg::*;

    localparam int PUSH_STEP = WW / 8;

    rmi_state_e    st;
    logic [VW-1:0] vec_r;
    logic [AW-1:0] tbl_r;
    logic [AW-1:0] fl_r;
    logic [WW-1:0] cs_old_r;
    logic [WW-1:0] ip_old_r;
    logic [AW-1:0] esp_r;
    logic [AW-1:0] ssb_r;
    logic          big_r;
    logic [AW-1:0] lim_r;
    logic [WW-1:0] ip_new_r;
    logic [WW-1:0] sel_new_r;

    logic [AW-1:0] tbl_addr;
    logic [AW-1:0] esp_dec;
    logic [AW-1:0] push_addr;
    logic [AW-1:0] flags_new;
    logic [AW-1:0] eip_new;
    logic [AW-1:0] base_new;
    logic          over_limit;
    logic          in_read;
    logic          in_push;

    // Inputs with no bearing on the sequence, gathered to mark them as unused
    logic unused_size_bits;
    assign unused_size_bits = ^{code_big, opsz_pfx, adsz_pfx, eip_in[AW-1:WW]};

    // Phase decode of the current step
    always_comb begin
        in_read = (st == ST_RD_IP) || (st == ST_RD_CS);
        in_push = (st == ST_PSH_FL) || (st == ST_PSH_CS) || (st == ST_PSH_IP);
    end

    rmi_vec_addr #(.AW(AW), .VW(VW), .ENT_SHIFT(ENT_SHIFT)) u_vec_addr (
        .tbl_base (tbl_r),
        .vec      (vec_r),
        .hi_half  (st == ST_RD_CS),
        .addr     (tbl_addr)
    );

    rmi_stack_ptr #(.AW(AW), .WW(WW), .STEP(PUSH_STEP)) u_stack_ptr (
        .esp_cur   (esp_r),
        .ss_base   (ssb_r),
        .big       (big_r),
        .esp_dec   (esp_dec),
        .push_addr (push_addr)
    );

    rmi_entry_result #(.AW(AW), .WW(WW), .SEG_SHIFT(SEG_SHIFT)) u_result (
        .flags_old  (fl_r),
        .ip_new     (ip_new_r),
        .sel_new    (sel_new_r),
        .cs_limit   (lim_r),
        .flags_new  (flags_new),
        .eip_new    (eip_new),
        .base_new   (base_new),
        .over_limit (over_limit)
    );

    // Memory port drive from the current step
    always_comb begin
        mem_req = in_read || in_push;
        mem_we  = in_push;
        mem_addr = in_push ? push_addr : (in_read ? tbl_addr : '0);
        case (st)
            ST_PSH_FL: mem_wdata = fl_r[WW-1:0];
            ST_PSH_CS: mem_wdata = cs_old_r;
            ST_PSH_IP: mem_wdata = ip_old_r;
            default:   mem_wdata = '0;
        endcase
    end

    // Status outputs
    always_comb begin
        busy = (st != ST_IDLE);
        done = (st == ST_FIN);
    end

    // Step sequencing, context capture and result load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            vec_r       <= '0;
            tbl_r       <= '0;
            fl_r        <= '0;
            cs_old_r    <= '0;
            ip_old_r    <= '0;
            esp_r       <= '0;
            ssb_r       <= '0;
            big_r       <= 1'b0;
            lim_r       <= '0;
            ip_new_r    <= '0;
            sel_new_r   <= '0;
            lim_fault   <= 1'b0;
            cs_sel_out  <= '0;
            cs_base_out <= '0;
            eip_out     <= '0;
            flags_out   <= '0;
            esp_out     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        vec_r    <= vec;
                        tbl_r    <= tbl_base;
                        fl_r     <= flags_in;
                        cs_old_r <= cs_sel_in;
                        ip_old_r <= eip_in[WW-1:0];
                        esp_r    <= esp_in;
                        ssb_r    <= ss_base;
                        big_r    <= ss_big;
                        lim_r    <= cs_limit;
                        st       <= ST_RD_IP;
                    end
                end
                ST_RD_IP: begin
                    if (mem_ack) begin
                        ip_new_r <= mem_rdata;
                        st       <= ST_RD_CS;
                    end
                end
                ST_RD_CS: begin
                    if (mem_ack) begin
                        sel_new_r <= mem_rdata;
                        st        <= ST_PSH_FL;
                    end
                end
                ST_PSH_FL: begin
                    if (mem_ack) begin
                        esp_r <= esp_dec;
                        st    <= ST_PSH_CS;
                    end
                end
                ST_PSH_CS: begin
                    if (mem_ack) begin
                        esp_r <= esp_dec;
                        st    <= ST_PSH_IP;
                    end
                end
                ST_PSH_IP: begin
                    if (mem_ack) begin
                        esp_r       <= esp_dec;
                        esp_out     <= esp_dec;
                        eip_out     <= eip_new;
                        cs_sel_out  <= sel_new_r;
                        cs_base_out <= base_new;
                        flags_out   <= flags_new;
                        lim_fault   <= over_limit;
                        st          <= ST_FIN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: a pending access holds still until acknowledged
    p_hold_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R10: completion is a single-cycle pulse followed by idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3: upper half of the handler pointer is zero
    p_eip_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (eip_out[AW-1:WW] == '0));

    // R4: code base tracks the published selector
    p_cs_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_base_out == (AW'(cs_sel_out) << SEG_SHIFT)));

    // R5: masked flag bits are clear on completion
    p_flags_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags_out[FL_IF] && !flags_out[FL_TF] &&
                  !flags_out[FL_RF] && !flags_out[FL_AC]));

    // R6: with the small stack the upper pointer half never moves on a push
    p_esp_hi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ack && !big_r) |=> (esp_r[AW-1:WW] == $past(esp_r[AW-1:WW])));

    // R8: fault flag agrees with the published pointer and latched limit
    p_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lim_fault == (eip_out > lim_r)));

endmodule

// File: tb/rmi_vector_entry_tb.sv
// Bench: behavioural reference stepped on every clock, compared at the falling edge.
module rmi_vector_entry_tb_top;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vec = '0;
    logic [31:0] tbl_base = '0, flags_in = '0, eip_in = '0, esp_in = '0;
    logic [31:0] ss_base = '0, cs_limit = '0;
    logic [15:0] cs_sel_in = '0;
    logic        ss_big = 1'b0, code_big = 1'b0, opsz_pfx = 1'b0, adsz_pfx = 1'b0;
    logic        mem_req, mem_we, busy, done, lim_fault;
    logic [31:0] mem_addr, cs_base_out, eip_out, flags_out, esp_out;
    logic [15:0] mem_wdata, cs_sel_out;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rmi_vector_entry dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec(vec), .tbl_base(tbl_base),
        .flags_in(flags_in), .cs_sel_in(cs_sel_in), .eip_in(eip_in), .esp_in(esp_in),
        .ss_base(ss_base), .ss_big(ss_big), .cs_limit(cs_limit), .code_big(code_big),
        .opsz_pfx(opsz_pfx), .adsz_pfx(adsz_pfx), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .lim_fault(lim_fault),
        .cs_sel_out(cs_sel_out), .cs_base_out(cs_base_out), .eip_out(eip_out),
        .flags_out(flags_out), .esp_out(esp_out)
    );

    int total = 0;
    int bad = 0;
    int ack_mode = 0;
    int ack_cnt = 0;
    bit finished = 0;

    // Byte memory shared by bench and model
    logic [7:0] mem [logic [31:0]];

    function automatic logic [15:0] rdw(input logic [31:0] a);
        logic [7:0] lo, hi;
        lo = mem.exists(a) ? mem[a] : 8'h00;
        hi = mem.exists(a + 32'd1) ? mem[a + 32'd1] : 8'h00;
        return {hi, lo};
    endfunction

    task automatic wrw(input logic [31:0] a, input logic [15:0] w);
        mem[a] = w[7:0];
        mem[a + 32'd1] = w[15:8];
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Reference model state
    int          step = 0;
    logic [7:0]  m_vec;
    logic [31:0] m_tbl, m_fl, m_eip, m_esp, m_ssb, m_lim;
    logic [15:0] m_cs, m_ip, m_sel;
    logic        m_big;
    logic [31:0] e_eip, e_base, e_fl, e_esp;
    logic [15:0] e_sel;
    logic        e_flt;

    function automatic logic [31:0] m_dec(input logic [31:0] p, input logic big);
        if (big) return p - 32'd2;
        return {p[31:16], p[15:0] - 16'd2};
    endfunction

    function automatic logic [31:0] m_paddr(input logic [31:0] p_after, input logic big);
        return m_ssb + (big ? p_after : {16'h0, p_after[15:0]});
    endfunction

    function automatic logic [15:0] m_push_word(input int s);
        if (s == 3) return m_fl[15:0];
        if (s == 4) return m_cs;
        return m_eip[15:0];
    endfunction

    // Model advance at the active edge, using bench-driven inputs only
    always @(posedge clk) begin
        if (!rst_n) step = 0;
        else begin
            case (step)
                0: if (start) begin
                    m_vec = vec; m_tbl = tbl_base; m_fl = flags_in; m_cs = cs_sel_in;
                    m_eip = eip_in; m_esp = esp_in; m_ssb = ss_base; m_big = ss_big;
                    m_lim = cs_limit; step = 1;
                end
                1: if (mem_ack) begin m_ip = mem_rdata; step = 2; end
                2: if (mem_ack) begin m_sel = mem_rdata; step = 3; end
                3, 4, 5: if (mem_ack) begin
                    m_esp = m_dec(m_esp, m_big);
                    wrw(m_paddr(m_esp, m_big), m_push_word(step));
                    if (step == 5) begin
                        e_eip = {16'h0, m_ip};
                        e_sel = m_sel;
                        e_base = {12'h0, m_sel, 4'h0};
                        e_fl = m_fl & ~32'h0005_0300;
                        e_esp = m_esp;
                        e_flt = (e_eip > m_lim);
                    end
                    step = step + 1;
                end
                default: step = 0;
            endcase
        end
    end

    // Per-cycle comparison, then drive of the memory response
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic exp_req, exp_we;
            logic [31:0] a;
            exp_req = (step >= 1 && step <= 5);
            exp_we = (step >= 3 && step <= 5);
            chk("R9 mem_req", {31'h0, mem_req}, {31'h0, exp_req});
            chk("R2 mem_we order", {31'h0, mem_we}, {31'h0, exp_we});
            chk("R10 busy", {31'h0, busy}, {31'h0, step != 0});
            chk("R10 done", {31'h0, done}, {31'h0, step == 6});
            if (step == 1 || step == 2) begin
                a = m_tbl + {22'h0, m_vec, 2'b00} + ((step == 2) ? 32'd2 : 32'd0);
                chk("R1 table address", mem_addr, a);
            end
            if (exp_we) begin
                chk("R6 push address", mem_addr, m_paddr(m_dec(m_esp, m_big), m_big));
                chk("R2 push data", {16'h0, mem_wdata}, {16'h0, m_push_word(step)});
            end
            if (step == 6) begin
                chk("R3 eip_out", eip_out, e_eip);
                chk("R4 cs_sel_out", {16'h0, cs_sel_out}, {16'h0, e_sel});
                chk("R4 cs_base_out", cs_base_out, e_base);
                chk("R5 flags_out", flags_out, e_fl);
                chk("R6 esp_out", esp_out, e_esp);
                chk("R8 lim_fault", {31'h0, lim_fault}, {31'h0, e_flt});
            end
        end
        mem_ack = (ack_mode == 0) ? 1'b1 : ((ack_cnt % 3) == 2);
        ack_cnt++;
        mem_rdata = rdw(mem_addr);
    end

    task automatic run(input logic [7:0] v, input logic [31:0] tb, input logic [31:0] fl,
                       input logic [15:0] cs, input logic [31:0] ip, input logic [31:0] sp,
                       input logic [31:0] ssb, input logic big, input logic [31:0] lim,
                       input logic d, input logic p66, input logic p67);
        @(negedge clk);
        vec = v; tbl_base = tb; flags_in = fl; cs_sel_in = cs; eip_in = ip; esp_in = sp;
        ss_base = ssb; ss_big = big; cs_limit = lim; code_big = d; opsz_pfx = p66;
        adsz_pfx = p67; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && step != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        total++; bad++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_up();
    end

    initial begin
        logic [31:0] r_eip, r_esp, r_fl;
        logic [15:0] r_sel;
        int n_done;
        // Vector table contents
        wrw(32'h0000_0084, 16'h5678); wrw(32'h0000_0086, 16'h1000);
        wrw(32'h0012_37FC, 16'hFFFE); wrw(32'h0012_37FE, 16'hF000);
        wrw(32'hFFFF_FFFC, 16'h0123); wrw(32'hFFFF_FFFE, 16'h2222);
        wrw(32'h0000_0000, 16'h4444); wrw(32'h0000_0002, 16'h0070);
        wrw(32'h0000_0040, 16'h8000); wrw(32'h0000_0042, 16'h0C00);

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", {31'h0, busy}, 32'h0);
        chk("R11 done", {31'h0, done}, 32'h0);
        chk("R11 mem_req", {31'h0, mem_req}, 32'h0);
        chk("R11 mem_we", {31'h0, mem_we}, 32'h0);
        chk("R11 lim_fault", {31'h0, lim_fault}, 32'h0);
        chk("R11 eip_out", eip_out, 32'h0);
        chk("R11 cs_base_out", cs_base_out, 32'h0);
        chk("R11 esp_out", esp_out, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: basic entry, small stack, table at zero
        run(8'h21, 32'h0, 32'h0000_0346, 16'h0700, 32'h0000_0123, 32'h1234_0100,
            32'h0002_0000, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        // R9: stalled acknowledges, relocated table, all flags set (R5)
        ack_mode = 1;
        run(8'hFF, 32'h0012_3400, 32'hFFFF_FFFF, 16'hABCD, 32'h0000_9876, 32'h0000_8000,
            32'h0010_0000, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        ack_mode = 0;
        // R1: table base wrap, offsets on both sides of the top of memory
        run(8'h01, 32'hFFFF_FFF8, 32'h0000_0202, 16'h0001, 32'h0000_0010, 32'h0000_0400,
            32'h0, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        run(8'h02, 32'hFFFF_FFF8, 32'h0000_0202, 16'h0001, 32'h0000_0010, 32'h0000_0400,
            32'h0, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        // R6: small stack wraps inside 64K, upper half kept
        run(8'h21, 32'h0, 32'h0, 16'h0002, 32'h0000_0044, 32'hABCD_0001,
            32'h0003_0000, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        chk("R6 small stack wrap esp_out", esp_out, 32'hABCD_FFFB);
        // R6: big stack crosses the 64K line
        run(8'h21, 32'h0, 32'h0, 16'h0002, 32'h0000_0044, 32'h0001_0002,
            32'h0004_0000, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        chk("R6 big stack esp_out", esp_out, 32'h0000_FFFC);
        // R8: handler offset beyond limit, then exactly at limit
        run(8'h10, 32'h0, 32'h0, 16'h0003, 32'h0, 32'h0000_2000, 32'h0, 1'b0,
            32'h0000_5432, 1'b0, 1'b0, 1'b0);
        chk("R8 beyond limit", {31'h0, lim_fault}, 32'h1);
        run(8'h10, 32'h0, 32'h0, 16'h0003, 32'h0, 32'h0000_2000, 32'h0, 1'b0,
            32'h0000_8000, 1'b0, 1'b0, 1'b0);
        chk("R8 at limit", {31'h0, lim_fault}, 32'h0);
        // R7: size bit and prefixes set versus clear give identical results
        run(8'h21, 32'h0, 32'h0000_1202, 16'h0555, 32'hDEAD_BEEF, 32'h0000_3000,
            32'h0005_0000, 1'b0, 32'h0000_FFFF, 1'b1, 1'b1, 1'b1);
        r_eip = eip_out; r_esp = esp_out; r_fl = flags_out; r_sel = cs_sel_out;
        chk("R7 eip upper half with D set", {16'h0, r_eip[31:16]}, 32'h0);
        run(8'h21, 32'h0, 32'h0000_1202, 16'h0555, 32'hDEAD_BEEF, 32'h0000_3000,
            32'h0005_0000, 1'b0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
        chk("R7 eip unaffected", eip_out, r_eip);
        chk("R7 esp unaffected", esp_out, r_esp);
        chk("R7 flags unaffected", flags_out, r_fl);
        chk("R7 selector unaffected", {16'h0, cs_sel_out}, {16'h0, r_sel});
        // R10: start held through busy, including the done cycle
        @(negedge clk);
        start = 1'b1;
        n_done = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (done) n_done++;
        end
        start = 1'b0;
        chk("R10 completions with start held", n_done, 2);
        for (int i = 0; i < 50 && step != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule